// File: doc/BRIEF.md
# NAND Sector Hamming ECC Generator and Syndrome Checker

This block computes a single-error-correcting Hamming code over one NAND sector while its bytes stream through the flash interface. Every data bit carries a 12-bit position: the byte index within the sector, followed by the bit index within the byte. Each set bit XORs its position into a high parity group and the complement of its position into a low parity group. Software reads the two groups from a raw register. It also gets a 24-bit code that is inverted, so that a fully erased sector produces the same all-ones pattern that erased spare bytes already hold.

A separate combinational checker compares the code stored with a sector against the code computed when the sector is read back. It reports one of four outcomes: clean, a correctable data bit (with the byte and bit to flip), a single flipped bit inside the stored code, or an uncorrectable error. The accumulator is started with a restart strobe and stopped and cleared by the register read strobe.

Top module: `nand_hamming_ecc`

## Requirements
- R1: While accumulation is running, each cycle with `dataValid` high folds `dataByte` into the parity and advances the byte position by one. The first byte after a restart is at position 0.
- R2: For each set data bit at position {byte index, bit index}, the high group XORs in that 12-bit position and the low group XORs in its complement. `eccRaw` holds the high group in bits 27:16 and the low group in bits 11:0, and its other bits read 0.
- R3: `eccCode` is the bitwise inverse of {high group, low group}. A sector of all 0xFF bytes therefore yields 24'hFFFFFF.
- R4: A cycle with `eccRead` high clears both groups and stops accumulation. Bytes presented afterwards are ignored until the next restart.
- R5: A cycle with `restart` high clears both groups and the byte position, and starts accumulation from the next cycle. Restart takes priority over a simultaneous read.
- R6: When `storedCode` equals `calcCode`, `status` is 0 (clean).
- R7: Take the syndrome as `storedCode` XOR `calcCode`. When its bits 11:0 XOR its bits 23:12 equal 12'hFFF and syndrome bits 23:15 are below SECTOR_BYTES, `status` is 1. In that case `fixByte` is syndrome bits 23:15 and `fixBit` is syndrome bits 14:12.
- R8: A syndrome that meets the complement test but whose bits 23:15 are not below SECTOR_BYTES gives `status` 3 (uncorrectable).
- R9: A syndrome with exactly one bit set, and which does not meet the complement test, gives `status` 2 (error in the stored code only).
- R10: Any other nonzero syndrome gives `status` 3. Whenever `status` is not 1, `fixByte` and `fixBit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Clear and start accumulation for a new sector |
| eccRead | input | 1 | Register read strobe; clears and stops accumulation |
| dataValid | input | 1 | Qualifies dataByte |
| dataByte | input | 8 | Sector data byte |
| eccRaw | output | 32 | Raw parity register (high group 27:16, low group 11:0) |
| eccCode | output | 24 | Packed, inverted 24-bit code |
| storedCode | input | 24 | Code saved with the sector |
| calcCode | input | 24 | Code computed on read-back |
| status | output | 2 | 0 clean, 1 data bit fix, 2 code bit error, 3 uncorrectable |
| fixByte | output | 9 | Byte index to correct |
| fixBit | output | 3 | Bit index to correct |

## Verification
The assertions take the classifier inputs to be steady across each clock edge. They also assume that the clearing strobes are only judged one cycle later, after the register update. The stimulus changes every input on the falling clock edge, and it never raises `restart` in the cycle after a read whose clearing effect an assertion is watching. Correctable syndromes beyond the sector limit are produced by a second instance built with a 256-byte sector. This keeps every checked syndrome inside the 24-bit code layout.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXDATA = 2'd1,
    ST_CODEERR = 2'd2,
    ST_FATAL   = 2'd3
  } eccStatus_e;

  typedef struct packed {
    logic clearAcc;
    logic accumulate;
  } eccStrobes_t;
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        restart,
  input  logic        eccRead,
  input  logic        dataValid,
  output eccStrobes_t strobes
);
  logic running;

  // restart takes priority over a read in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)        running <= 1'b0;
    else if (restart) running <= 1'b1;
    else if (eccRead) running <= 1'b0;
  end

  always_comb begin
    strobes.clearAcc   = restart | eccRead;
    strobes.accumulate = running & dataValid & ~(restart | eccRead);
  end
endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter int BYTE_IDX_W = 9,
  parameter int RAW_W      = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  eccStrobes_t          strobes,
  input  logic [7:0]           dataByte,
  output logic [RAW_W-1:0]     eccRaw,
  output logic [2*(BYTE_IDX_W+3)-1:0] eccCode
);
  localparam int GROUP_W = BYTE_IDX_W + 3;
  localparam int HI_LSB  = RAW_W / 2;

  logic [BYTE_IDX_W-1:0] byteAddr;
  logic [GROUP_W-1:0]    hiAcc, loAcc;
  logic [GROUP_W-1:0]    byteHi, byteLo;

  // per-byte contribution: position for the high group, complement for the low
  always_comb begin
    byteHi = '0;
    byteLo = '0;
    for (int i = 0; i < 8; i++) begin
      if (dataByte[i]) begin
        byteHi = byteHi ^ {byteAddr, 3'(i)};
        byteLo = byteLo ^ ~{byteAddr, 3'(i)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAcc) begin
      hiAcc    <= '0;
      loAcc    <= '0;
      byteAddr <= '0;
    end else if (strobes.accumulate) begin
      hiAcc    <= hiAcc ^ byteHi;
      loAcc    <= loAcc ^ byteLo;
      byteAddr <= byteAddr + 1'b1;
    end
  end

  always_comb begin
    eccRaw = '0;
    eccRaw[HI_LSB +: GROUP_W] = hiAcc;
    eccRaw[0 +: GROUP_W]      = loAcc;
    eccCode = ~{hiAcc, loAcc};
  end
endmodule

// File: rtl/nand_ecc_syndrome.sv
module nand_ecc_syndrome
  import nand_ecc_pkg::*;
#(
  parameter int BYTE_IDX_W   = 9,
  parameter int SECTOR_BYTES = 512
) (
  input  logic [2*(BYTE_IDX_W+3)-1:0] storedCode,
  input  logic [2*(BYTE_IDX_W+3)-1:0] calcCode,
  output eccStatus_e                  status,
  output logic [BYTE_IDX_W-1:0]       fixByte,
  output logic [2:0]                  fixBit
);
  localparam int GROUP_W = BYTE_IDX_W + 3;
  localparam int CODE_W  = 2 * GROUP_W;

  logic [CODE_W-1:0]     syn;
  logic [GROUP_W-1:0]    synHi, synLo;
  logic [BYTE_IDX_W-1:0] idx;
  logic                  complementary;

  always_comb begin
    syn           = storedCode ^ calcCode;
    synLo         = syn[GROUP_W-1:0];
    synHi         = syn[CODE_W-1:GROUP_W];
    idx           = synHi[GROUP_W-1:3];
    complementary = &(synHi ^ synLo);
    status  = ST_FATAL;
    fixByte = '0;
    fixBit  = '0;
    if (syn == '0) begin
      status = ST_CLEAN;
    end else if (complementary) begin
      if (32'(idx) < SECTOR_BYTES) begin
        status  = ST_FIXDATA;
        fixByte = idx;
        fixBit  = synHi[2:0];
      end
    end else if ((syn & (syn - 1'b1)) == '0) begin
      status = ST_CODEERR;
    end
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nand_ecc_pkg::*;
#(
  parameter int BYTE_IDX_W   = 9,
  parameter int SECTOR_BYTES = 512,
  parameter int RAW_W        = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        restart,
  input  logic                        eccRead,
  input  logic                        dataValid,
  input  logic [7:0]                  dataByte,
  output logic [RAW_W-1:0]            eccRaw,
  output logic [2*(BYTE_IDX_W+3)-1:0] eccCode,
  input  logic [2*(BYTE_IDX_W+3)-1:0] storedCode,
  input  logic [2*(BYTE_IDX_W+3)-1:0] calcCode,
  output logic [1:0]                  status,
  output logic [BYTE_IDX_W-1:0]       fixByte,
  output logic [2:0]                  fixBit
);
  eccStrobes_t strobes;
  eccStatus_e  statusE;

  nand_ecc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart), .eccRead(eccRead),
    .dataValid(dataValid), .strobes(strobes)
  );

  nand_ecc_datapath #(.BYTE_IDX_W(BYTE_IDX_W), .RAW_W(RAW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataByte(dataByte),
    .eccRaw(eccRaw), .eccCode(eccCode)
  );

  nand_ecc_syndrome #(.BYTE_IDX_W(BYTE_IDX_W), .SECTOR_BYTES(SECTOR_BYTES)) u_syn (
    .storedCode(storedCode), .calcCode(calcCode), .status(statusE),
    .fixByte(fixByte), .fixBit(fixBit)
  );

  assign status = statusE;
endmodule

// File: rtl/nand_hamming_ecc_chk.sv
module nand_hamming_ecc_chk #(
  parameter int BYTE_IDX_W   = 9,
  parameter int SECTOR_BYTES = 512,
  parameter int RAW_W        = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        restart,
  input logic                        eccRead,
  input logic [RAW_W-1:0]            eccRaw,
  input logic [2*(BYTE_IDX_W+3)-1:0] eccCode,
  input logic [2*(BYTE_IDX_W+3)-1:0] storedCode,
  input logic [2*(BYTE_IDX_W+3)-1:0] calcCode,
  input logic [1:0]                  status,
  input logic [BYTE_IDX_W-1:0]       fixByte,
  input logic [2:0]                  fixBit
);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    eccRead |=> eccRaw == '0);

  a_r4_idle_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (eccRead && !restart) ##1 !restart |=> eccRaw == '0);

  a_r5_restart_clean_code: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> &eccCode);

  a_r6_clean_iff_equal: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd0) == (storedCode == calcCode));

  a_r7_fix_in_range: assert property (@(posedge clk) disable iff (!rstN)
    status == 2'd1 |-> 32'(fixByte) < SECTOR_BYTES);

  a_r9_code_err_onehot: assert property (@(posedge clk) disable iff (!rstN)
    status == 2'd2 |-> $countones(storedCode ^ calcCode) == 1);

  a_r10_fix_zero: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'd1 |-> (fixByte == '0 && fixBit == '0));
endmodule

bind nand_hamming_ecc nand_hamming_ecc_chk #(
  .BYTE_IDX_W(BYTE_IDX_W), .SECTOR_BYTES(SECTOR_BYTES), .RAW_W(RAW_W)
) u_chk (
  .clk(clk), .rstN(rstN), .restart(restart), .eccRead(eccRead),
  .eccRaw(eccRaw), .eccCode(eccCode), .storedCode(storedCode),
  .calcCode(calcCode), .status(status), .fixByte(fixByte), .fixBit(fixBit)
);

// File: tb/nand_hamming_ecc_tb.sv
module nand_hamming_ecc_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic restart = 1'b0, eccRead = 1'b0, dataValid = 1'b0;
  logic [7:0]  dataByte = '0;
  logic [31:0] eccRaw;
  logic [23:0] eccCode;
  logic [23:0] storedCode = '0, calcCode = '0;
  logic [1:0]  status;
  logic [8:0]  fixByte;
  logic [2:0]  fixBit;
  logic [31:0] sRaw;
  logic [23:0] sCode;
  logic [23:0] sStored = '0, sCalc = '0;
  logic [1:0]  sStatus;
  logic [8:0]  sFixByte;
  logic [2:0]  sFixBit;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nand_hamming_ecc u_dut (
    .clk(clk), .rstN(rstN), .restart(restart), .eccRead(eccRead),
    .dataValid(dataValid), .dataByte(dataByte), .eccRaw(eccRaw),
    .eccCode(eccCode), .storedCode(storedCode), .calcCode(calcCode),
    .status(status), .fixByte(fixByte), .fixBit(fixBit)
  );

  nand_hamming_ecc #(.SECTOR_BYTES(256)) u_small (
    .clk(clk), .rstN(rstN), .restart(1'b0), .eccRead(1'b0),
    .dataValid(1'b0), .dataByte(8'h00), .eccRaw(sRaw),
    .eccCode(sCode), .storedCode(sStored), .calcCode(sCalc),
    .status(sStatus), .fixByte(sFixByte), .fixBit(sFixBit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(int kind, int b);
    if (kind == 0) return 8'hFF;
    return 8'((b * 37 + 11) ^ (b >> 3));
  endfunction

  function automatic logic [23:0] modelCode(int kind, int fb, int fbit);
    logic [11:0] h, l;
    logic [7:0]  v;
    h = '0; l = '0;
    for (int b = 0; b < 512; b++) begin
      v = patByte(kind, b);
      if (b == fb) v[fbit] = ~v[fbit];
      for (int i = 0; i < 8; i++)
        if (v[i]) begin
          h = h ^ 12'(b * 8 + i);
          l = l ^ ~12'(b * 8 + i);
        end
    end
    return ~{h, l};
  endfunction

  function automatic logic [31:0] rawOf(logic [23:0] code);
    return {4'h0, ~code[23:12], 4'h0, ~code[11:0]};
  endfunction

  task automatic pulseRestart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk); eccRead = 1'b1;
    @(negedge clk); eccRead = 1'b0;
  endtask

  task automatic feed(int kind, int count, int fb, int fbit);
    logic [7:0] v;
    for (int b = 0; b < count; b++) begin
      @(negedge clk);
      v = patByte(kind, b);
      if (b == fb) v[fbit] = ~v[fbit];
      dataValid = 1'b1; dataByte = v;
    end
    @(negedge clk); dataValid = 1'b0;
  endtask

  task automatic testReset();
    check("R2 reset raw", eccRaw, 32'h0);
    check("R3 reset code", 32'(eccCode), 32'hFFFFFF);
  endtask

  task automatic testErased();
    pulseRestart();
    feed(0, 512, -1, 0);
    check("R3 erased code", 32'(eccCode), 32'hFFFFFF);
    check("R2 erased raw", eccRaw, 32'h0);
  endtask

  task automatic testPattern();
    logic [23:0] exp;
    exp = modelCode(1, -1, 0);
    pulseRestart();
    feed(1, 512, -1, 0);
    check("R1 pattern code", 32'(eccCode), 32'(exp));
    check("R2 pattern raw", eccRaw, rawOf(exp));
  endtask

  task automatic testReadAndIdle();
    pulseRead();
    check("R4 read clears raw", eccRaw, 32'h0);
    feed(1, 20, -1, 0);
    check("R4 idle bytes ignored", eccRaw, 32'h0);
  endtask

  task automatic testRestartMid();
    pulseRestart();
    feed(1, 100, -1, 0);
    pulseRestart();
    check("R5 restart clears", 32'(eccCode), 32'hFFFFFF);
    feed(1, 512, -1, 0);
    check("R5 restart position zero", 32'(eccCode), 32'(modelCode(1, -1, 0)));
  endtask

  task automatic testDataFlip(int fb, int fbit);
    logic [23:0] good;
    pulseRestart(); feed(1, 512, -1, 0); good = eccCode; pulseRead();
    pulseRestart(); feed(1, 512, fb, fbit);
    storedCode = good; calcCode = eccCode;
    @(negedge clk);
    check("R7 flip status", 32'(status), 32'd1);
    check("R7 flip byte", 32'(fixByte), 32'(fb));
    check("R7 flip bit", 32'(fixBit), 32'(fbit));
    pulseRead();
  endtask

  task automatic testClassify();
    logic [23:0] good;
    good = modelCode(1, -1, 0);
    storedCode = good; calcCode = good;
    @(negedge clk);
    check("R6 clean", 32'(status), 32'd0);
    storedCode = good ^ 24'h000080;
    @(negedge clk);
    check("R9 code bit error", 32'(status), 32'd2);
    check("R10 no fix on code error", 32'({fixByte, fixBit}), 32'd0);
    storedCode = good ^ 24'h000081;
    @(negedge clk);
    check("R10 double error", 32'(status), 32'd3);
    storedCode = good ^ 24'h003001;
    @(negedge clk);
    check("R10 mixed error", 32'(status), 32'd3);
  endtask

  task automatic testSectorLimit();
    logic [11:0] hi;
    hi = {9'd300, 3'd2};
    sStored = {hi, ~hi}; sCalc = '0;
    @(negedge clk);
    check("R8 index beyond sector", 32'(sStatus), 32'd3);
    check("R10 no fix beyond sector", 32'({sFixByte, sFixBit}), 32'd0);
    hi = {9'd255, 3'd1};
    sStored = {hi, ~hi};
    @(negedge clk);
    check("R7 last byte of small sector", 32'(sStatus), 32'd1);
    check("R7 small fix byte", 32'(sFixByte), 32'd255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testErased();
    testPattern();
    testReadAndIdle();
    testRestartMid();
    pulseRead();
    testDataFlip(100, 5);
    testDataFlip(511, 7);
    testDataFlip(0, 0);
    testClassify();
    testSectorLimit();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule